// File: doc/BRIEF.md
# Dual Serial Pattern Detector

This block watches a serial bit stream that arrives one bit per clock edge and raises a single match line whenever the five most recent bits form either of two fixed patterns: `00111` or `01001`. In both patterns the leftmost bit is the one that arrives first. Two independent sequence recognizers run side by side, one per pattern. Each recognizer is a Moore machine whose state is the length of the longest pattern prefix matched so far. Their hit strobes are merged into one registered match output.

A bit that breaks a partial match does not always send a recognizer back to its empty state. The next state is the longest prefix of the pattern that is also a suffix of the bits received. Because of this, back-to-back occurrences of one pattern are found even when they overlap. The same holds when the tail of one pattern begins the other. A synchronous reset discards all history.

Top module: `dual_pattern_watch`

## Requirements
- R1: While `rst` is high at a rising edge, both recognizers return to the empty-prefix state and `matchOut` is 0 in the following cycle, whatever `bitIn` is.
- R2: After the five bits 0,0,1,1,1 are sampled on consecutive non-reset edges (in that order), `matchOut` is 1 in the cycle after the edge that sampled the last of them.
- R3: After the five bits 0,1,0,0,1 are sampled on consecutive non-reset edges, `matchOut` is 1 in the cycle after the edge that sampled the last of them.
- R4: `matchOut` is a registered pulse. It stays high for one cycle only, unless the next sampled bit completes another match.
- R5: A mismatching bit moves a recognizer to the longest pattern prefix that is a suffix of the received bits. For example, 0,0,0,1,1,1 still matches `00111`.
- R6: Occurrences of the same pattern may overlap. For example, 0,1,0,0,1,0,0,1 gives two matches, after the fifth and the eighth bit.
- R7: The tail of one pattern can start the other. For example, 0,1,0,0,1,1,1 gives a match after the fifth bit (`01001`) and after the seventh bit (`00111`).
- R8: `matchOut` is 0 whenever the last five bits sampled since reset are neither pattern, or fewer than five bits have been sampled since reset.
- R9: A reset in the middle of a partial match discards it. For example, 0,0,1,1, then reset, then 1 gives no match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one stream bit is sampled per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bitIn | input | 1 | Serial stream bit |
| matchOut | output | 1 | High for the cycle after either pattern completes |

## Verification
The bench goes after the fallback transitions. A recognizer that always drops to the empty state on a mismatch would miss `000111` and the overlapping `01001001`, and it would lose the second match in `0100111`, where one pattern's tail starts the other. It drives reset in the middle of partial matches, so a design that keeps stale prefix state would report a match after fewer than five fresh bits. Long random streams with injected patterns are compared against a five-bit history model. This catches off-by-one output timing and pulses that stay high too long.

// File: rtl/pattern_watch_pkg.sv
package pattern_watch_pkg;
  localparam int PAT_LEN = 5;
  localparam int NUM_PAT = 2;
  // Leftmost (MSB) bit arrives first.
  localparam logic [PAT_LEN-1:0] PATTERNS [NUM_PAT] = '{5'b00111, 5'b01001};

  typedef struct packed {
    logic [NUM_PAT-1:0] hit;
    logic               clear;
  } ctrl_strobe_t;
endpackage

// File: rtl/seq_recognizer.sv
module seq_recognizer #(
  parameter int LEN = 5,
  parameter logic [LEN-1:0] PATTERN = '0,
  localparam int SW = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bitIn,
  output logic hitNext
);
  logic [SW-1:0] prefixLen;
  logic [SW-1:0] nextLen;

  // Longest pattern prefix that is a suffix of (matched prefix, new bit).
  function automatic logic [SW-1:0] advance(input logic [SW-1:0] cur, input logic b);
    logic [LEN:0] seq;
    logic [SW-1:0] best;
    logic ok;
    int curLen;
    int idx;
    curLen = int'(cur);
    best = '0;
    seq = '0;
    for (int i = 0; i <= LEN; i++) begin
      if (i < curLen) seq[i] = PATTERN[LEN-1-i];
      else if (i == curLen) seq[i] = b;
    end
    for (int k = 1; k <= LEN; k++) begin
      if (k <= curLen + 1) begin
        ok = 1'b1;
        for (int j = 0; j < LEN; j++) begin
          if (j < k) begin
            idx = curLen + 1 - k + j;
            if (seq[idx] != PATTERN[LEN-1-j]) ok = 1'b0;
          end
        end
        if (ok) best = SW'(k);
      end
    end
    return best;
  endfunction

  always_comb nextLen = advance(prefixLen, bitIn);

  always_ff @(posedge clk) begin
    if (rst) prefixLen <= '0;
    else     prefixLen <= nextLen;
  end

  assign hitNext = (nextLen == SW'(LEN));
endmodule

// File: rtl/watch_ctrl.sv
module watch_ctrl
  import pattern_watch_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         bitIn,
  output ctrl_strobe_t strobe
);
  logic [NUM_PAT-1:0] hitVec;

  for (genvar g = 0; g < NUM_PAT; g++) begin : g_rec
    seq_recognizer #(
      .LEN(PAT_LEN),
      .PATTERN(PATTERNS[g])
    ) u_rec (
      .clk(clk),
      .rst(rst),
      .bitIn(bitIn),
      .hitNext(hitVec[g])
    );
  end

  always_comb begin
    strobe.hit   = hitVec;
    strobe.clear = rst;
  end
endmodule

// File: rtl/match_datapath.sv
module match_datapath
  import pattern_watch_pkg::*;
(
  input  logic         clk,
  input  ctrl_strobe_t strobe,
  output logic         matchOut
);
  always_ff @(posedge clk) begin
    if (strobe.clear) matchOut <= 1'b0;
    else              matchOut <= |strobe.hit;
  end
endmodule

// File: rtl/dual_pattern_watch.sv
module dual_pattern_watch
  import pattern_watch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bitIn,
  output logic matchOut
);
  ctrl_strobe_t strobe;

  watch_ctrl u_ctrl (
    .clk(clk),
    .rst(rst),
    .bitIn(bitIn),
    .strobe(strobe)
  );

  match_datapath u_dp (
    .clk(clk),
    .strobe(strobe),
    .matchOut(matchOut)
  );
endmodule

// File: rtl/dual_pattern_watch_chk.sv
module dual_pattern_watch_chk
  import pattern_watch_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic bitIn,
  input logic matchOut
);
  logic [PAT_LEN-1:0] hist;
  logic [2:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      seen <= '0;
    end else begin
      hist <= {hist[PAT_LEN-2:0], bitIn};
      if (seen < 3'd5) seen <= seen + 3'd1;
    end
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> !matchOut);

  // R2
  pattern_a_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (seen == 3'd5 && hist == PATTERNS[0]) |-> matchOut);

  // R3
  pattern_b_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (seen == 3'd5 && hist == PATTERNS[1]) |-> matchOut);

  // R8
  no_false_match_chk: assert property (@(posedge clk) disable iff (rst)
    matchOut |-> (seen == 3'd5 && (hist == PATTERNS[0] || hist == PATTERNS[1])));
endmodule

bind dual_pattern_watch dual_pattern_watch_chk u_chk (.*);

// File: tb/dual_pattern_watch_bench.sv
`timescale 1ns/1ps
module dual_pattern_watch_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitIn = 1'b0;
  logic matchOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [4:0] mHist = '0;
  int mSeen = 0;
  logic prevExp = 1'b0;

  always #10 clk = ~clk;

  dual_pattern_watch u_dual_pattern_watch (
    .clk(clk), .rst(rst), .bitIn(bitIn), .matchOut(matchOut)
  );

  function automatic logic expMatch(input logic [4:0] h, input int s);
    return (s >= 5) && (h == 5'b00111 || h == 5'b01001);
  endfunction

  task automatic step(input logic b, input logic r, input string tag);
    logic e;
    string t;
    bitIn = b;
    rst = r;
    @(posedge clk);
    if (r) begin
      mHist = '0;
      mSeen = 0;
    end else begin
      mHist = {mHist[3:0], b};
      if (mSeen < 5) mSeen++;
    end
    e = r ? 1'b0 : expMatch(mHist, mSeen);
    @(negedge clk);
    t = tag;
    if (t == "") begin
      if (e && mHist == 5'b00111) t = "R2";
      else if (e) t = "R3";
      else if (prevExp) t = "R4";
      else t = "R8";
    end
    checks++;
    if (matchOut !== e) begin
      errors++;
      $display("FAIL %s: matchOut=%b expected=%b", t, matchOut, e);
    end
    prevExp = e;
  endtask

  task automatic feed(input logic [15:0] bits, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) step(bits[i], 1'b0, tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: reset with both input values
    step(1'b1, 1'b1, "R1");
    step(1'b0, 1'b1, "R1");
    step(1'b1, 1'b1, "R1");
    // R2 and R3 basic
    feed(16'b00111, 5, "R2");
    step(1'b1, 1'b0, "R4");
    feed(16'b01001, 5, "R3");
    step(1'b1, 1'b0, "R4");
    // R5 fallback on extra zero
    step(1'b1, 1'b1, "R1");
    feed(16'b000111, 6, "R5");
    // R6 overlapping same pattern
    step(1'b0, 1'b1, "R1");
    feed(16'b01001001, 8, "R6");
    // R7 cross-pattern tail
    step(1'b0, 1'b1, "R1");
    feed(16'b0100111, 7, "R7");
    // R9 reset in mid-match
    feed(16'b0011, 4, "R9");
    step(1'b1, 1'b1, "R9");
    step(1'b1, 1'b0, "R9");
    feed(16'b01, 2, "R9");
    step(1'b0, 1'b1, "R9");
    feed(16'b001, 3, "R9");
    // R8 long idle streams
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, "R8");
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, "R8");
    // Random stream with injected patterns
    for (int i = 0; i < 3000; i++) begin
      int pick;
      pick = int'($urandom_range(0, 15));
      if (pick == 0) feed(16'b00111, 5, "");
      else if (pick == 1) feed(16'b01001, 5, "");
      else if (pick == 2 && ($urandom_range(0, 20) == 0)) step(1'($urandom), 1'b1, "R1");
      else step(1'($urandom), 1'b0, "");
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule